// File: doc/BRIEF.md
# Flash Read Wait-State and Busy-Arbitration Controller

This block sits between a simple bus read port and a flash array. Every read that reaches the array is stretched by a programmable number of extra wait cycles. The array then has time to deliver its data at the current clock rate. The requester raises `rd_req_i` with an address and holds it until `rdy_o` pulses. The block drives `arr_rd_o` and `arr_addr_o` to the array for the whole access window.

The array can be busy with a program or erase operation when a read comes in. A 3-bit policy code then selects one of five responses:
- an immediate error;
- a plain stall;
- a stall with a sticky stall notification;
- a stall that also requests an abort of the running operation;
- an abort together with a sticky abort notification.

A stalled read waits until the busy flag drops, either naturally or because of the abort. It then performs a normal read with the full wait count. Both notification flags are write-one-to-clear through `irq_clr_i`.

The wait count and the policy code are held in internal configuration registers. These are loaded through `cfg_we_i`. The wait count is taken when an array access starts. The policy code is taken when a request is first accepted.

Top module: `flash_rd_timing_ctrl`

## Requirements
- R1: After reset the wait count is 2, the policy code is 3'b111, both notification flags are 0, and `rdy_o`, `err_o`, `abort_o` and `arr_rd_o` are 0.
- R2: A read accepted while the array is idle asserts `arr_rd_o` with `arr_addr_o` equal to the request address. `rdy_o` is high for exactly one cycle, 1+W clock edges after the edge that accepts the request, with `err_o` low (W = wait count).
- R3: Every wait count from 0 to 31 is honoured, including both ends of the range.
- R4: With policy bit 2 clear (codes 3'b000 to 3'b011), a read accepted while `arr_busy_i` is high returns `rdy_o` and `err_o` together for one cycle, on the edge after acceptance, and `arr_rd_o` stays low.
- R5: Policy 3'b111 stalls a read during busy with `rdy_o` low. It sets no flag and raises no `abort_o`.
- R6: Policy 3'b110 stalls the read and sets the stall flag (`stall_irq_o`), with no abort.
- R7: Policy 3'b101 stalls the read and holds `abort_o` high while stalled, without setting the abort flag.
- R8: Policy 3'b100 stalls the read, holds `abort_o` high while stalled and sets the abort flag (`abort_irq_o`). The stall flag is not set.
- R9: When busy drops during a stall, `rdy_o` pulses 1+W edges after the first edge that sees busy low, and `abort_o` falls at that edge.
- R10: The flags are sticky and clear on a one in `irq_clr_i` (bit 0 stall, bit 1 abort). They are set only once, on the edge that accepts the stalled read. A flag cleared during the stall stays clear.
- R11: A configuration write made during an access does not change that access's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load configuration registers |
| cfg_wait_i | input | 5 | Wait count to load |
| cfg_rwb_i | input | 3 | Busy-read policy code to load |
| irq_clr_i | input | 2 | Write-one-to-clear for stall (bit 0) and abort (bit 1) flags |
| rd_req_i | input | 1 | Read request, held until rdy_o |
| rd_addr_i | input | 24 | Read address |
| rdy_o | output | 1 | Read completion pulse |
| err_o | output | 1 | Error response, valid with rdy_o |
| arr_busy_i | input | 1 | Array busy with program/erase |
| arr_rd_o | output | 1 | Array read access window |
| arr_addr_o | output | 24 | Address presented to the array |
| abort_o | output | 1 | Abort request to the program/erase engine |
| stall_irq_o | output | 1 | Sticky stall notification |
| abort_irq_o | output | 1 | Sticky abort notification |

## Verification
A corrupted wait counter shows as a `rdy_o` pulse arriving early or late. That is visible within at most 32 cycles of the access start. A controller state stuck in stall keeps `rdy_o` low after busy drops, and the bench's bounded wait reports the missing pulse. A mis-decoded policy code shows on the edge after acceptance: the wrong flag, `abort_o` level or error pulse appears at once. A flag that is set more than once surfaces when it reappears after a mid-stall clear.

// File: rtl/flash_rwb_pkg.sv
package flash_rwb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACC   = 2'd1,
      ST_STALL = 2'd2,
      ST_ERR   = 2'd3
   } frt_state_e;

   typedef struct packed {
      logic err;
      logic stall_irq;
      logic abort;
      logic abort_irq;
   } rwb_act_t;

   localparam int unsigned RWB_W = 3;
   localparam int unsigned N_IRQ = 2;
   localparam int unsigned IRQ_STALL = 0;
   localparam int unsigned IRQ_ABORT = 1;

endpackage

// File: rtl/frt_cfg_regs.sv
module frt_cfg_regs
   import flash_rwb_pkg::*;
#(
   parameter int unsigned WS_W    = 5,
   parameter int unsigned WS_RST  = 2,
   parameter logic [2:0]  RWB_RST = 3'b111
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [WS_W-1:0]  ws_i,
   input  logic [RWB_W-1:0] rwb_i,
   output logic [WS_W-1:0]  ws_o,
   output logic [RWB_W-1:0] rwb_o
);
   localparam logic [WS_W-1:0] WS_INIT = WS_RST[WS_W-1:0];

   if (WS_RST >= (1 << WS_W)) begin : g_bad_rst
      $error("frt_cfg_regs: WS_RST does not fit in WS_W bits");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ws_o  <= WS_INIT;
         rwb_o <= RWB_RST;
      end else if (we_i) begin
         ws_o  <= ws_i;
         rwb_o <= rwb_i;
      end
   end
endmodule

// File: rtl/frt_rwb_policy.sv
module frt_rwb_policy
   import flash_rwb_pkg::*;
(
   input  logic [RWB_W-1:0] code_i,
   output rwb_act_t         act_o
);
   always_comb begin
      act_o = '0;
      if (!code_i[2]) begin
         act_o.err = 1'b1;
      end else begin
         unique case (code_i[1:0])
            2'b11: act_o = '0;
            2'b10: act_o.stall_irq = 1'b1;
            2'b01: act_o.abort = 1'b1;
            2'b00: begin
               act_o.abort     = 1'b1;
               act_o.abort_irq = 1'b1;
            end
            default: act_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/frt_wait_cnt.sv
module frt_wait_cnt #(
   parameter int unsigned WS_W = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic [WS_W-1:0] val_i,
   input  logic            en_i,
   output logic            zero_o
);
   logic [WS_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (en_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/frt_irq_flags.sv
module frt_irq_flags #(
   parameter int unsigned N = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q <= 1'b0;
         end else if (set_i[i]) begin
            q <= 1'b1;
         end else if (clr_i[i]) begin
            q <= 1'b0;
         end
      end
      assign flag_o[i] = q;
   end
endmodule

// File: rtl/flash_rd_timing_ctrl.sv
module flash_rd_timing_ctrl
   import flash_rwb_pkg::*;
#(
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned WS_W    = 5,
   parameter int unsigned WS_RST  = 2,
   parameter logic [2:0]  RWB_RST = 3'b111
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [WS_W-1:0]   cfg_wait_i,
   input  logic [2:0]        cfg_rwb_i,
   input  logic [1:0]        irq_clr_i,
   input  logic              rd_req_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              rdy_o,
   output logic              err_o,
   input  logic              arr_busy_i,
   output logic              arr_rd_o,
   output logic [ADDR_W-1:0] arr_addr_o,
   output logic              abort_o,
   output logic              stall_irq_o,
   output logic              abort_irq_o
);
   if (ADDR_W == 0 || WS_W == 0) begin : g_bad_w
      $error("flash_rd_timing_ctrl: widths must be non-zero");
   end

   frt_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic              abort_q;
   logic [WS_W-1:0]   ws_cfg;
   logic [RWB_W-1:0]  rwb_cfg;
   rwb_act_t          act;
   logic              cnt_zero, cnt_load;
   logic              accept, accept_busy;
   logic [N_IRQ-1:0]  irq_set, irq_flags;

   frt_cfg_regs #(.WS_W(WS_W), .WS_RST(WS_RST), .RWB_RST(RWB_RST)) u_cfg (
      .clk_i (clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
      .ws_i  (cfg_wait_i), .rwb_i(cfg_rwb_i),
      .ws_o  (ws_cfg), .rwb_o(rwb_cfg)
   );

   frt_rwb_policy u_pol (.code_i(rwb_cfg), .act_o(act));

   assign accept      = (state_q == ST_IDLE) && rd_req_i;
   assign accept_busy = accept && arr_busy_i;

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (rd_req_i) begin
               if (!arr_busy_i) begin
                  state_d  = ST_ACC;
                  cnt_load = 1'b1;
               end else if (act.err) begin
                  state_d = ST_ERR;
               end else begin
                  state_d = ST_STALL;
               end
            end
         end
         ST_ACC:   if (cnt_zero) state_d = ST_IDLE;
         ST_STALL: begin
            if (!arr_busy_i) begin
               state_d  = ST_ACC;
               cnt_load = 1'b1;
            end
         end
         ST_ERR:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   frt_wait_cnt #(.WS_W(WS_W)) u_cnt (
      .clk_i (clk_i), .rst_ni(rst_ni), .load_i(cnt_load),
      .val_i (ws_cfg), .en_i(state_q == ST_ACC), .zero_o(cnt_zero)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         abort_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q  <= rd_addr_i;
            abort_q <= arr_busy_i && act.abort && !act.err;
         end
      end
   end

   assign irq_set[IRQ_STALL] = accept_busy && act.stall_irq;
   assign irq_set[IRQ_ABORT] = accept_busy && act.abort_irq;

   frt_irq_flags #(.N(N_IRQ)) u_irq (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(irq_set),
      .clr_i(irq_clr_i), .flag_o(irq_flags)
   );

   assign rdy_o       = ((state_q == ST_ACC) && cnt_zero) || (state_q == ST_ERR);
   assign err_o       = (state_q == ST_ERR);
   assign arr_rd_o    = (state_q == ST_ACC);
   assign arr_addr_o  = addr_q;
   assign abort_o     = (state_q == ST_STALL) && abort_q;
   assign stall_irq_o = irq_flags[IRQ_STALL];
   assign abort_irq_o = irq_flags[IRQ_ABORT];
endmodule

// File: rtl/flash_rd_timing_ctrl_chk.sv
module flash_rd_timing_ctrl_chk #(
   parameter int unsigned ADDR_W = 24
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              rdy_o,
   input logic              err_o,
   input logic              arr_rd_o,
   input logic [ADDR_W-1:0] arr_addr_o,
   input logic              abort_o,
   input logic              abort_irq_o,
   input logic              arr_busy_i
);
   assert_err_with_rdy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> rdy_o);
   assert_err_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> !err_o);
   assert_err_no_access_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> !arr_rd_o);
   assert_rdy_from_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdy_o && !err_o) |-> arr_rd_o);
   assert_rdy_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdy_o |=> !rdy_o);
   assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arr_rd_o && $past(arr_rd_o)) |-> $stable(arr_addr_o));
   assert_abort_blocks_rdy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> !rdy_o && !arr_rd_o);
   assert_abort_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(abort_irq_o) |-> abort_o);
   assert_abort_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (abort_o && !arr_busy_i) |=> !abort_o);
endmodule

bind flash_rd_timing_ctrl flash_rd_timing_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .rdy_o(rdy_o), .err_o(err_o),
   .arr_rd_o(arr_rd_o), .arr_addr_o(arr_addr_o), .abort_o(abort_o),
   .abort_irq_o(abort_irq_o), .arr_busy_i(arr_busy_i)
);

// File: tb/flash_rd_timing_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_rd_timing_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_wait = '0;
   logic [2:0]  cfg_rwb = '0;
   logic [1:0]  irq_clr = '0;
   logic        rd_req = 1'b0;
   logic [23:0] rd_addr = '0;
   logic        arr_busy = 1'b0;
   logic        rdy, err, arr_rd, abort, stall_irq, abort_irq;
   logic [23:0] arr_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flash_rd_timing_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wait_i(cfg_wait),
      .cfg_rwb_i(cfg_rwb), .irq_clr_i(irq_clr), .rd_req_i(rd_req),
      .rd_addr_i(rd_addr), .rdy_o(rdy), .err_o(err), .arr_busy_i(arr_busy),
      .arr_rd_o(arr_rd), .arr_addr_o(arr_addr), .abort_o(abort),
      .stall_irq_o(stall_irq), .abort_irq_o(abort_irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic cfg_write(input logic [4:0] w, input logic [2:0] code);
      cfg_we = 1'b1; cfg_wait = w; cfg_rwb = code;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic clear_flags();
      irq_clr = 2'b11; step(); irq_clr = 2'b00;
   endtask

   // count edges until rdy is seen; returns count (0 on timeout)
   task automatic wait_rdy(output int n, output bit e);
      n = 0; e = 1'b0;
      for (int i = 1; i <= 80; i++) begin
         step();
         if (rdy) begin n = i; e = err; break; end
      end
   endtask

   task automatic idle_read(input logic [23:0] a, input int w, input string req);
      int n; bit e;
      rd_addr = a; rd_req = 1'b1;
      step();
      chk(arr_rd == 1'b1 && arr_addr == a, req, int'(arr_addr), int'(a));
      n = 1; e = err;
      if (!rdy) begin
         wait_rdy(n, e);
         if (n != 0) n = n + 1;
      end
      rd_req = 1'b0;
      chk(n == w + 1, req, n, w + 1);
      chk(e == 1'b0, req, int'(e), 0);
      step();
      chk(rdy == 1'b0 && arr_rd == 1'b0, req, int'(rdy), 0);
   endtask

   task automatic test_reset();
      chk(rdy == 0 && err == 0 && abort == 0 && arr_rd == 0, "R1", int'({rdy, err, abort, arr_rd}), 0);
      chk(stall_irq == 0 && abort_irq == 0, "R1", int'({stall_irq, abort_irq}), 0);
      idle_read(24'h000100, 2, "R1");
   endtask

   task automatic test_latency();
      cfg_write(5'd0, 3'b111);  idle_read(24'h00ABCD, 0, "R3");
      cfg_write(5'd31, 3'b111); idle_read(24'h123456, 31, "R3");
      cfg_write(5'd5, 3'b111);  idle_read(24'hFFFFFF, 5, "R2");
   endtask

   task automatic test_cfg_mid_access();
      int n; bit e;
      cfg_write(5'd6, 3'b111);
      rd_addr = 24'h000042; rd_req = 1'b1;
      step();
      cfg_we = 1'b1; cfg_wait = 5'd1; step(); cfg_we = 1'b0;
      wait_rdy(n, e);
      rd_req = 1'b0;
      chk(n + 2 == 7, "R11", n + 2, 7);
      step();
   endtask

   task automatic test_error(input logic [2:0] code);
      cfg_write(5'd3, code);
      arr_busy = 1'b1; rd_addr = 24'h000777; rd_req = 1'b1;
      step();
      chk(rdy && err && !arr_rd, "R4", int'({rdy, err, arr_rd}), 6);
      rd_req = 1'b0;
      step();
      chk(!rdy && !err && !arr_rd, "R4", int'({rdy, err, arr_rd}), 0);
      chk(!stall_irq && !abort_irq && !abort, "R4", int'({stall_irq, abort_irq, abort}), 0);
      arr_busy = 1'b0;
   endtask

   task automatic test_stall(input logic [2:0] code, input bit exp_si, input bit exp_ab,
                             input bit exp_ai, input bit clr_mid, input string req);
      int n; bit e; bit ok;
      cfg_write(5'd4, code);
      clear_flags();
      arr_busy = 1'b1; rd_addr = 24'h0000AA; rd_req = 1'b1;
      step();
      chk(stall_irq == exp_si, req, int'(stall_irq), int'(exp_si));
      chk(abort_irq == exp_ai, req, int'(abort_irq), int'(exp_ai));
      ok = 1'b1;
      for (int i = 0; i < 5; i++) begin
         if (rdy || err || arr_rd || abort != exp_ab) ok = 1'b0;
         if (clr_mid && i == 1) irq_clr = 2'b11;
         step();
         irq_clr = 2'b00;
      end
      chk(ok, req, int'(abort), int'(exp_ab));
      if (clr_mid)
         chk(!stall_irq && !abort_irq, "R10", int'({stall_irq, abort_irq}), 0);
      else
         chk(stall_irq == exp_si && abort_irq == exp_ai, "R10",
             int'({stall_irq, abort_irq}), int'({exp_si, exp_ai}));
      arr_busy = 1'b0;
      wait_rdy(n, e);
      rd_req = 1'b0;
      chk(n == 5 && !e, "R9", n, 5);
      chk(!abort, "R9", int'(abort), 0);
      step();
   endtask

   initial begin
      #100000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #12 rst_n = 1'b1;
      step();
      test_reset();
      // R5 reset policy stalls silently
      test_stall(3'b111, 0, 0, 0, 0, "R5");
      test_latency();
      test_cfg_mid_access();
      test_error(3'b000);
      test_error(3'b011);
      test_stall(3'b111, 0, 0, 0, 0, "R5");
      test_stall(3'b110, 1, 0, 0, 0, "R6");
      test_stall(3'b101, 0, 1, 0, 0, "R7");
      test_stall(3'b100, 0, 1, 1, 0, "R8");
      test_stall(3'b110, 1, 0, 0, 1, "R10");
      test_stall(3'b100, 0, 1, 1, 1, "R10");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule